// File: doc/BRIEF.md
# Two-Stage Segmented Page Translation Unit

This block turns a 32-bit virtual address into a 30-bit physical address in two lookups. The top three address bits pick one of eight on-chip segment entries. Each entry holds the base address of that segment's page table and the number of pages the table covers. The 17-bit virtual page number is first checked against that page count. If it is in range, the block fetches one page-table word from memory at the base plus the page number. The 18-bit physical page number in that word is joined to the untouched 12-bit page offset.

Software fills the segment entries through a one-cycle write port. Translations arrive on a valid/ready request port, and the block serves them one at a time. Each result comes back as a single-cycle response pulse, carrying either a physical address or a fault flag. Page-table words are read over one request/response memory port. Results are not cached, so every translation costs a segment lookup followed by a memory read, unless the range check fails first.

Top module: `segpage_xlate`

## Requirements
- R1: After reset every segment entry has a page count of 0, so any translation faults without issuing a memory read. While the block is idle `rq_ready` is 1 and `mr_valid` is 0.
- R2: Field positions in the virtual address: segment number in bits 31:29, virtual page number in bits 28:12, page offset in bits 11:0.
- R3: A translation faults, with no memory read issued, when the virtual page number is greater than or equal to the segment's 18-bit page count. A count of 131072 (2^17) admits every page number.
- R4: The page-table word is read at the 30-bit word address `base + vpn`, taken modulo 2^30.
- R5: Field positions in a page-table word: bit 31 is the valid flag and bits 17:0 are the physical page number. Bits 30:18 are ignored. A valid word gives `rs_fault` = 0 and `rs_paddr` = {ppn, offset}.
- R6: A page-table word with bit 31 clear produces a fault response.
- R7: At most one translation is in flight. `rq_ready` is 0 from acceptance until the cycle after the response. `rs_valid` is high for exactly one cycle per accepted request.
- R8: Once raised, `mr_valid` stays high with a stable `mr_addr` until `mr_ready` is seen.
- R9: A table write is applied at the clock edge where `tw_en` is 1. Requests accepted afterwards see the new entry, and the other segments are unchanged.
- R10: `rs_paddr` is 0 whenever a fault is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tw_en | input | 1 | Segment entry write strobe |
| tw_seg | input | 3 | Segment entry being written |
| tw_base | input | 30 | Page-table base word address |
| tw_bound | input | 18 | Number of pages in the segment's table |
| rq_valid | input | 1 | Translation request valid |
| rq_ready | output | 1 | Block can accept a request |
| rq_vaddr | input | 32 | Virtual address to translate |
| rs_valid | output | 1 | One-cycle response strobe |
| rs_fault | output | 1 | Translation failed |
| rs_paddr | output | 30 | Physical address (0 on fault) |
| mr_valid | output | 1 | Page-table read request valid |
| mr_ready | input | 1 | Memory accepts the read request |
| mr_addr | output | 30 | Page-table word address |
| md_valid | input | 1 | Read data valid |
| md_data | input | 32 | Page-table word |

## Verification
The bench builds the block with its default widths: a 3-bit segment field, a 17-bit page number, a 12-bit offset and a 30-bit base. This keeps the extreme page counts (0, 1 and 2^17) within reach, along with a base close enough to the top of the 30-bit space for `base + vpn` to wrap. All eight segments are loaded and swept at the page numbers that sit on and beside each bound. One segment is swept in full so that both valid and invalid page-table words are returned. The memory model stalls `mr_ready` and varies its response latency, so the request-hold and single-flight rules are tested under back-pressure.

// File: rtl/segpage_pkg.sv
package segpage_pkg;

    localparam int VA_W        = 32;
    localparam int SEG_W       = 3;
    localparam int VPN_W       = 17;
    localparam int OFF_W       = 12;
    localparam int BASE_W      = 30;
    localparam int PPN_W       = 18;
    localparam int PTE_W       = 32;
    localparam int PTE_VLD_BIT = PTE_W - 1;
    localparam int BND_W       = VPN_W + 1;
    localparam int N_SEG       = 1 << SEG_W;
    localparam int PA_W        = PPN_W + OFF_W;

    typedef struct packed {
        logic [SEG_W-1:0] seg;
        logic [VPN_W-1:0] vpn;
        logic [OFF_W-1:0] off;
    } vaddr_t;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [BND_W-1:0]  bound;
    } seg_ent_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FETCH,
        ST_AWAIT,
        ST_REPLY
    } xl_state_t;

    function automatic logic vpn_in_range(logic [VPN_W-1:0] vpn, logic [BND_W-1:0] bound);
        return {1'b0, vpn} < bound;
    endfunction

    function automatic logic [BASE_W-1:0] pte_addr(seg_ent_t e, logic [VPN_W-1:0] vpn);
        return e.base + BASE_W'(vpn);
    endfunction

endpackage

// File: rtl/segpage_seg_table.sv
module segpage_seg_table
    import segpage_pkg::*;
#(
    parameter int N     = N_SEG,
    parameter int IDX_W = SEG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  seg_ent_t         wr_ent,
    input  logic [IDX_W-1:0] rd_idx,
    output seg_ent_t         rd_ent
);

    seg_ent_t rd_vec [N];

    for (genvar g = 0; g < N; g++) begin : g_ent
        seg_ent_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                q <= wr_ent;
            end
        end
        assign rd_vec[g] = q;
    end

    assign rd_ent = rd_vec[rd_idx];

endmodule

// File: rtl/segpage_ctrl.sv
module segpage_ctrl
    import segpage_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rq_valid,
    output logic              rq_ready,
    input  logic [VA_W-1:0]   rq_vaddr,
    output logic [SEG_W-1:0]  lk_seg,
    input  seg_ent_t          lk_ent,
    output logic              mr_valid,
    input  logic              mr_ready,
    output logic [BASE_W-1:0] mr_addr,
    input  logic              md_valid,
    input  logic [PTE_W-1:0]  md_data,
    output logic              rs_valid,
    output logic              rs_fault,
    output logic [PA_W-1:0]   rs_paddr
);

    xl_state_t         st;
    vaddr_t            va_q;
    logic [BASE_W-1:0] addr_q;
    logic [PA_W-1:0]   pa_q;
    logic              flt_q;

    logic              pte_ok;
    logic [PPN_W-1:0]  pte_ppn;
    logic              unused_pte_bits;

    assign pte_ok          = md_data[PTE_VLD_BIT];
    assign pte_ppn         = md_data[PPN_W-1:0];
    assign unused_pte_bits = ^md_data[PTE_VLD_BIT-1:PPN_W];

    assign lk_seg   = va_q.seg;
    assign rq_ready = (st == ST_IDLE);
    assign mr_valid = (st == ST_FETCH);
    assign mr_addr  = addr_q;
    assign rs_valid = (st == ST_REPLY);
    assign rs_fault = flt_q;
    assign rs_paddr = pa_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            va_q   <= '0;
            addr_q <= '0;
            pa_q   <= '0;
            flt_q  <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (rq_valid) begin
                        va_q <= vaddr_t'(rq_vaddr);
                        st   <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (vpn_in_range(va_q.vpn, lk_ent.bound)) begin
                        addr_q <= pte_addr(lk_ent, va_q.vpn);
                        st     <= ST_FETCH;
                    end else begin
                        flt_q <= 1'b1;
                        pa_q  <= '0;
                        st    <= ST_REPLY;
                    end
                end
                ST_FETCH: begin
                    if (mr_ready) begin
                        st <= ST_AWAIT;
                    end
                end
                ST_AWAIT: begin
                    if (md_valid) begin
                        flt_q <= ~pte_ok;
                        pa_q  <= pte_ok ? {pte_ppn, va_q.off} : '0;
                        st    <= ST_REPLY;
                    end
                end
                ST_REPLY: begin
                    st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/segpage_xlate.sv
module segpage_xlate
    import segpage_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tw_en,
    input  logic [SEG_W-1:0]  tw_seg,
    input  logic [BASE_W-1:0] tw_base,
    input  logic [BND_W-1:0]  tw_bound,
    input  logic              rq_valid,
    output logic              rq_ready,
    input  logic [VA_W-1:0]   rq_vaddr,
    output logic              rs_valid,
    output logic              rs_fault,
    output logic [PA_W-1:0]   rs_paddr,
    output logic              mr_valid,
    input  logic              mr_ready,
    output logic [BASE_W-1:0] mr_addr,
    input  logic              md_valid,
    input  logic [PTE_W-1:0]  md_data
);

    logic [SEG_W-1:0] lk_seg;
    seg_ent_t         lk_ent;
    seg_ent_t         wr_ent;

    assign wr_ent = '{base: tw_base, bound: tw_bound};

    segpage_seg_table #(.N(N_SEG), .IDX_W(SEG_W)) u_tab (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (tw_en),
        .wr_idx (tw_seg),
        .wr_ent (wr_ent),
        .rd_idx (lk_seg),
        .rd_ent (lk_ent)
    );

    segpage_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .rq_valid (rq_valid),
        .rq_ready (rq_ready),
        .rq_vaddr (rq_vaddr),
        .lk_seg   (lk_seg),
        .lk_ent   (lk_ent),
        .mr_valid (mr_valid),
        .mr_ready (mr_ready),
        .mr_addr  (mr_addr),
        .md_valid (md_valid),
        .md_data  (md_data),
        .rs_valid (rs_valid),
        .rs_fault (rs_fault),
        .rs_paddr (rs_paddr)
    );

endmodule

// File: rtl/segpage_xlate_chk.sv
module segpage_xlate_chk
    import segpage_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rq_valid,
    input logic              rq_ready,
    input logic [OFF_W-1:0]  rq_off,
    input logic              rs_valid,
    input logic              rs_fault,
    input logic [PA_W-1:0]   rs_paddr,
    input logic              mr_valid,
    input logic              mr_ready,
    input logic [BASE_W-1:0] mr_addr
);

    logic [OFF_W-1:0] off_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            if (rq_valid && rq_ready) begin
                off_q  <= rq_off;
                busy_q <= 1'b1;
            end else if (rs_valid) begin
                busy_q <= 1'b0;
            end
        end
    end

    assert_idle_no_read_R1: assert property (@(posedge clk) disable iff (rst)
        rq_ready |-> !mr_valid);

    assert_offset_kept_R5: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && !rs_fault) |-> (rs_paddr[OFF_W-1:0] == off_q));

    assert_single_flight_R7: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> !rq_ready);

    assert_resp_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        rs_valid |=> !rs_valid);

    assert_hold_request_R8: assert property (@(posedge clk) disable iff (rst)
        (mr_valid && !mr_ready) |=> (mr_valid && $stable(mr_addr)));

    assert_fault_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && rs_fault) |-> (rs_paddr == '0));

endmodule

bind segpage_xlate segpage_xlate_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rq_valid (rq_valid),
    .rq_ready (rq_ready),
    .rq_off   (rq_vaddr[11:0]),
    .rs_valid (rs_valid),
    .rs_fault (rs_fault),
    .rs_paddr (rs_paddr),
    .mr_valid (mr_valid),
    .mr_ready (mr_ready),
    .mr_addr  (mr_addr)
);

// File: tb/segpage_xlate_bench.sv
`timescale 1ns/1ps
module segpage_xlate_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tw_en = 1'b0;
    logic [2:0]  tw_seg = '0;
    logic [29:0] tw_base = '0;
    logic [17:0] tw_bound = '0;
    logic        rq_valid = 1'b0;
    logic        rq_ready;
    logic [31:0] rq_vaddr = '0;
    logic        rs_valid;
    logic        rs_fault;
    logic [29:0] rs_paddr;
    logic        mr_valid;
    logic        mr_ready;
    logic [29:0] mr_addr;
    logic        md_valid;
    logic [31:0] md_data;

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;

    int          cyc = 0;
    int          mem_reqs = 0;
    logic [29:0] last_addr = '0;
    int          lat_left = 0;

    logic [29:0] seg_base [8];
    int          seg_bnd  [8];

    always #2.5 clk = ~clk;

    segpage_xlate u_segpage_xlate (
        .clk(clk), .rst(rst),
        .tw_en(tw_en), .tw_seg(tw_seg), .tw_base(tw_base), .tw_bound(tw_bound),
        .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_vaddr(rq_vaddr),
        .rs_valid(rs_valid), .rs_fault(rs_fault), .rs_paddr(rs_paddr),
        .mr_valid(mr_valid), .mr_ready(mr_ready), .mr_addr(mr_addr),
        .md_valid(md_valid), .md_data(md_data)
    );

    // Page-table contents: bit 31 valid, bits 30:18 filler, bits 17:0 ppn (R5)
    function automatic logic [31:0] pte_of(input logic [29:0] a);
        logic        v;
        logic [17:0] p;
        v = (a % 30'd11) != 30'd4;
        p = 18'(a * 30'd37 + 30'd5);
        return {v, a[12:0], p};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Memory model: stalls the request channel and varies latency
    initial begin
        mr_ready = 1'b0;
        md_valid = 1'b0;
        md_data  = '0;
        forever begin
            @(negedge clk);
            cyc++;
            md_valid = 1'b0;
            if (lat_left > 0) begin
                lat_left--;
                if (lat_left == 0) begin
                    md_valid = 1'b1;
                    md_data  = pte_of(last_addr);
                end
            end else begin
                md_data = 32'hDEAD_0000 ^ 32'(cyc);
            end
            mr_ready = (cyc % 3) != 0;
            if (mr_valid === 1'b1 && mr_ready) begin
                mem_reqs++;
                last_addr = mr_addr;
                lat_left  = 1 + (cyc % 4);
            end
        end
    end

    task automatic table_write(input int s, input logic [29:0] b, input int bd);
        @(negedge clk);
        tw_en    = 1'b1;
        tw_seg   = 3'(s);
        tw_base  = b;
        tw_bound = 18'(bd);
        seg_base[s] = b;
        seg_bnd[s]  = bd;
        @(negedge clk);
        tw_en = 1'b0;
    endtask

    task automatic xlate_check(input int s, input int vpn, input int off, input string tag);
        logic [31:0] va;
        int          n0;
        int          guard;
        bit          busy_ok;
        bit          got_flt;
        logic [29:0] got_pa;
        logic [29:0] exp_addr;
        logic [31:0] pte;
        bit          exp_flt;
        logic [29:0] exp_pa;
        bit          exp_rd;

        // R2: seg 31:29, vpn 28:12, offset 11:0
        va = {3'(s), 17'(vpn), 12'(off)};
        n0 = mem_reqs;
        @(negedge clk);
        check(rq_ready === 1'b1, "R7 ready before request", 32'(rq_ready), 32'd1);
        rq_valid = 1'b1;
        rq_vaddr = va;
        @(negedge clk);
        rq_valid = 1'b0;
        rq_vaddr = 32'hFFFF_FFFF;
        guard   = 0;
        busy_ok = 1;
        while (rs_valid !== 1'b1 && guard < 100) begin
            if (rq_ready !== 1'b0) busy_ok = 0;
            @(negedge clk);
            guard++;
        end
        if (rq_ready !== 1'b0) busy_ok = 0;
        check(guard < 100, "R7 response arrives", 32'(guard), 32'd0);
        check(busy_ok, "R7 ready low while busy", 32'(busy_ok), 32'd1);
        got_flt = rs_fault;
        got_pa  = rs_paddr;
        @(negedge clk);
        check(rs_valid === 1'b0, "R7 response single pulse", 32'(rs_valid), 32'd0);

        exp_rd   = vpn < seg_bnd[s];
        exp_addr = seg_base[s] + 30'(vpn);
        pte      = pte_of(exp_addr);
        exp_flt  = !exp_rd || !pte[31];
        exp_pa   = exp_flt ? 30'd0 : {pte[17:0], 12'(off)};

        check((mem_reqs - n0) == (exp_rd ? 1 : 0),
              exp_rd ? {tag, " R4 one read"} : {tag, " R3 no read on bound fault"},
              32'(mem_reqs - n0), exp_rd ? 32'd1 : 32'd0);
        if (exp_rd)
            check(last_addr == exp_addr, {tag, " R4 read address"}, 32'(last_addr), 32'(exp_addr));
        check(got_flt == exp_flt,
              !exp_rd ? {tag, " R3 fault"} : (pte[31] ? {tag, " R5 no fault"} : {tag, " R6 invalid entry fault"}),
              32'(got_flt), 32'(exp_flt));
        check(got_pa == exp_pa, exp_flt ? {tag, " R10 paddr zero"} : {tag, " R5 paddr"},
              32'(got_pa), 32'(exp_pa));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            seg_base[i] = '0;
            seg_bnd[i]  = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        check(rq_ready === 1'b1, "R1 ready after reset", 32'(rq_ready), 32'd1);
        check(rs_valid === 1'b0, "R1 no response after reset", 32'(rs_valid), 32'd0);
        check(mr_valid === 1'b0, "R1 no read after reset", 32'(mr_valid), 32'd0);
        for (int s = 0; s < 8; s++)
            xlate_check(s, s * 7, s * 33, "R1 cleared table");

        table_write(0, 30'h0000_0100, 0);
        table_write(1, 30'h3FFF_FFFF, 1);
        table_write(2, 30'h3FFF_0000, 131072);
        table_write(3, 30'h0000_1234, 5);
        table_write(4, 30'h0ABC_0000, 131071);
        table_write(5, 30'h0000_0000, 16);
        table_write(6, 30'h1555_5555, 3);
        table_write(7, 30'h2000_0000, 100);

        // Sweep each segment at and around its bound (R3, R4, R5)
        for (int s = 0; s < 8; s++) begin
            int lst [7];
            lst = '{0, 1, seg_bnd[s] - 1, seg_bnd[s], seg_bnd[s] + 1, 131071, seg_bnd[s] / 2};
            for (int k = 0; k < 7; k++) begin
                if (lst[k] >= 0 && lst[k] <= 131071)
                    xlate_check(s, lst[k], (k * 16'h5A3 + s) & 12'hFFF, "R3 sweep");
            end
        end

        // Full sweep of a small segment hits invalid entries (R6)
        for (int v = 0; v < 20; v++)
            xlate_check(5, v, (v * 91) & 12'hFFF, "R6 sweep");

        // Wrap of base + vpn (R4)
        xlate_check(2, 70000, 12'hABC, "R4 wrap");
        xlate_check(1, 0, 12'hFFF, "R4 top base");

        // R9: rewrite one segment, others unchanged
        table_write(3, 30'h0000_1234, 0);
        xlate_check(3, 0, 12'h010, "R9 rewritten");
        xlate_check(4, 0, 12'h020, "R9 neighbour");
        table_write(3, 30'h0200_0000, 40);
        xlate_check(3, 39, 12'h030, "R9 new base");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule